// File: doc/BRIEF.md
# Bus Clock Divider Field Encoder

This block turns a requested clock divide ratio into the timing fields that a serial bus controller needs: a power-of-two prescale exponent, an SCL high count and an SCL low count. The ratio is the integer quotient of the source clock and the target bus rate, and it is computed elsewhere. The block also produces a mode word that selects either high-speed operation with a short timeout or normal operation with no timeout.

A one-cycle `start` pulse loads the ratio and the high-speed request. The block then halves the working ratio once per clock until the value is below 16. A sticky flag collects every bit that is shifted out, and that flag is added back at the end so that the result rounds up. The reduced ratio is split into low and high counts. When the results are ready, `done` pulses for one cycle, and the packed timing and mode words hold until the next completion.

A request that carries a zero rate is rejected. It completes at once with `bad_rate` set and leaves both words unchanged.

Top module: `clkdiv_field_encoder`

## Requirements
- R1: After reset, `busy`, `done` and `bad_rate` are 0, `timing_word` is 32'h7700_0300 and `mode_word` is 0.
- R2: While the working ratio is 16 or more, it is halved once per cycle. The number of halvings is the exponent, placed in `timing_word[3:0]`.
- R3: Every bit shifted out is ORed into a sticky flag. The reduced ratio is the final working value plus that flag, so 17 reduces to 9 and 31 reduces to 16.
- R4: With reduced ratio N, the low count is N/2-1 (integer division) in `timing_word[19:16]`. The high count is N-low-2 in `timing_word[23:20]`. All other bits always equal 32'h7700_0300.
- R5: A reduced ratio below 2 is treated as 2, giving low = high = 0.
- R6: If the exponent reaches 15 while the working value is still 16 or more, shifting stops and the result is exponent 15 with low = high = 7.
- R7: A start with `rate_zero`=1 gives `done` with `bad_rate`=1 one cycle later and leaves `timing_word` and `mode_word` unchanged. A valid completion clears `bad_rate`.
- R8: For a valid completion with `hs_req`=1 at start, `mode_word` = 8'h37: bits [2:0] are the high-speed enables and [7:4] is a timeout of 3. With `hs_req`=0, `mode_word` = 8'h00, meaning no timeout.
- R9: For a valid start sampled at edge c, `busy` is high from edge c+1, and `done` pulses after edge c+1+k, where k is the number of halvings. The output words change only on a completion.
- R10: `start` is ignored while `busy` is high. It starts no extra completion and does not alter the result in progress.
- R11: A `start` in the cycle where `done` is high is accepted, so requests can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a calculation (sampled when idle) |
| ratio | input | 32 | Source clock to bus rate ratio |
| hs_req | input | 1 | Request high-speed mode |
| rate_zero | input | 1 | Requested rate is zero, so reject |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle completion pulse |
| bad_rate | output | 1 | Last completion was a rejection |
| timing_word | output | 32 | Packed base, high, low and exponent fields |
| mode_word | output | 8 | High-speed enables and timeout |

## Verification
The completion pulse of one request and the acceptance of the next `start` can fall in the same cycle. The driver waits for `busy` to drop and raises `start` exactly in the cycle where `done` is high. The scoreboard then checks that the first result is reported with its computed values and cycle, and that the second result arrives after exactly its own latency. A rejection issued in that same done cycle is also checked: it must keep the word that was just produced.

// File: rtl/clkdiv_field_encoder.sv
module clkdiv_field_encoder #(
  parameter int RATIO_W = 32,
  parameter int FIELD_W = 4,
  parameter int WORD_W = 32,
  parameter int MODE_W = 8,
  parameter logic [WORD_W-1:0] TIMING_BASE = 32'h7700_0300,
  parameter int EXP_LSB = 0,
  parameter int LOW_LSB = 16,
  parameter int HIGH_LSB = 20,
  parameter int TO_LSB = 4,
  parameter int HS_TIMEOUT = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [RATIO_W-1:0] ratio,
  input  logic               hs_req,
  input  logic               rate_zero,
  output logic               busy,
  output logic               done,
  output logic               bad_rate,
  output logic [WORD_W-1:0]  timing_word,
  output logic [MODE_W-1:0]  mode_word
);
  localparam int LIMIT = 2 ** FIELD_W;
  localparam int RW = FIELD_W + 1;
  localparam logic [FIELD_W-1:0] EXP_MAX = '1;
  localparam logic [MODE_W-1:0] HS_BITS = MODE_W'(7);

  typedef enum logic {S_IDLE, S_SHIFT} state_t;

  state_t             state;
  logic [RATIO_W-1:0] work;
  logic [FIELD_W-1:0] exp_q;
  logic               sticky_q;
  logic               hs_q;

  logic               more, can_shift;
  logic [RW-1:0]      red_sum, red, red_c, low_w, high_w;
  logic [WORD_W-1:0]  word_next;
  logic [MODE_W-1:0]  mode_next;

  assign busy      = (state == S_SHIFT);
  assign more      = work >= RATIO_W'(LIMIT);
  assign can_shift = more && (exp_q != EXP_MAX);

  assign red_sum = {1'b0, work[FIELD_W-1:0]} + RW'(sticky_q);
  assign red     = more ? RW'(LIMIT) : red_sum;
  assign red_c   = (red < RW'(2)) ? RW'(2) : red;
  assign low_w   = (red_c >> 1) - RW'(1);
  assign high_w  = red_c - low_w - RW'(2);

  assign word_next = TIMING_BASE
                   | (WORD_W'(high_w[FIELD_W-1:0]) << HIGH_LSB)
                   | (WORD_W'(low_w[FIELD_W-1:0]) << LOW_LSB)
                   | (WORD_W'(exp_q) << EXP_LSB);
  assign mode_next = hs_q ? ((MODE_W'(HS_TIMEOUT) << TO_LSB) | HS_BITS) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      work        <= '0;
      exp_q       <= '0;
      sticky_q    <= 1'b0;
      hs_q        <= 1'b0;
      done        <= 1'b0;
      bad_rate    <= 1'b0;
      timing_word <= TIMING_BASE;
      mode_word   <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            if (rate_zero) begin
              done     <= 1'b1;
              bad_rate <= 1'b1;
            end else begin
              work     <= ratio;
              exp_q    <= '0;
              sticky_q <= 1'b0;
              hs_q     <= hs_req;
              state    <= S_SHIFT;
            end
          end
        end
        S_SHIFT: begin
          if (can_shift) begin
            work     <= work >> 1;
            sticky_q <= sticky_q | work[0];
            exp_q    <= exp_q + 1'b1;
          end else begin
            timing_word <= word_next;
            mode_word   <= mode_next;
            bad_rate    <= 1'b0;
            done        <= 1'b1;
            state       <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/clkdiv_field_encoder_chk.sv
module clkdiv_field_encoder_chk #(
  parameter int FIELD_W = 4,
  parameter int WORD_W = 32,
  parameter int MODE_W = 8,
  parameter logic [WORD_W-1:0] TIMING_BASE = 32'h7700_0300,
  parameter int LOW_LSB = 16,
  parameter int HIGH_LSB = 20,
  parameter int TO_LSB = 4,
  parameter int HS_TIMEOUT = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              bad_rate,
  input logic [WORD_W-1:0] timing_word,
  input logic [MODE_W-1:0] mode_word
);
  localparam logic [WORD_W-1:0] FIELD_MASK =
      (WORD_W'(2 ** FIELD_W - 1) << HIGH_LSB) |
      (WORD_W'(2 ** FIELD_W - 1) << LOW_LSB) |
      WORD_W'(2 ** FIELD_W - 1);

  logic [FIELD_W-1:0] lo_f, hi_f;
  assign lo_f = timing_word[LOW_LSB +: FIELD_W];
  assign hi_f = timing_word[HIGH_LSB +: FIELD_W];

  p_word_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(timing_word) && $stable(mode_word)));

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_reject_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && bad_rate) |-> ($stable(timing_word) && $stable(mode_word)));

  p_split_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !bad_rate) |-> ((hi_f == lo_f) || (hi_f == lo_f + 1'b1)));

  p_base_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (timing_word & ~FIELD_MASK) == TIMING_BASE);

  p_mode_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_word[0] == (mode_word[TO_LSB +: 4] == 4'(HS_TIMEOUT)));
endmodule

bind clkdiv_field_encoder clkdiv_field_encoder_chk #(
  .FIELD_W(FIELD_W), .WORD_W(WORD_W), .MODE_W(MODE_W),
  .TIMING_BASE(TIMING_BASE), .LOW_LSB(LOW_LSB), .HIGH_LSB(HIGH_LSB),
  .TO_LSB(TO_LSB), .HS_TIMEOUT(HS_TIMEOUT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .bad_rate(bad_rate), .timing_word(timing_word), .mode_word(mode_word)
);

// File: tb/test_clkdiv_field_encoder.sv
module test_clkdiv_field_encoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [31:0] ratio = '0;
  logic hs_req = 1'b0;
  logic rate_zero = 1'b0;
  logic busy, done, bad_rate;
  logic [31:0] timing_word;
  logic [7:0] mode_word;

  always #2.5 clk = ~clk;

  clkdiv_field_encoder i_clkdiv_field_encoder (
    .clk(clk), .rst_n(rst_n), .start(start), .ratio(ratio), .hs_req(hs_req),
    .rate_zero(rate_zero), .busy(busy), .done(done), .bad_rate(bad_rate),
    .timing_word(timing_word), .mode_word(mode_word)
  );

  typedef struct {
    logic [31:0] word;
    logic [7:0]  mode;
    logic        bad;
    int          at;
    string       tag;
  } item_t;

  item_t sb[$];
  int checks = 0, failures = 0, cyc = 0, pushed = 0, seen = 0;
  logic [31:0] model_word = 32'h7700_0300;
  logic [7:0]  model_mode = 8'h00;
  bit finished = 0;

  always @(posedge clk) cyc++;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic void model(input logic [31:0] r, input logic hs,
                                output logic [31:0] w, output logic [7:0] m, output int lat);
    int e = 0;
    logic [31:0] x = r;
    logic st = 1'b0;
    int red, lo, hi;
    while (x >= 16 && e < 15) begin
      st = st | x[0];
      x = x >> 1;
      e++;
    end
    if (x >= 16) red = 16;
    else red = int'(x) + int'(st);
    if (red < 2) red = 2;
    lo = red / 2 - 1;
    hi = red - lo - 2;
    w = 32'h7700_0300 | (32'(hi) << 20) | (32'(lo) << 16) | 32'(e);
    m = hs ? 8'h37 : 8'h00;
    lat = e + 1;
  endfunction

  task automatic send(input logic [31:0] r, input logic hs, input logic z, input string tag);
    item_t it;
    int lat;
    logic [31:0] w;
    logic [7:0] m;
    @(negedge clk);
    while (busy) @(negedge clk);
    if (z) begin
      it.word = model_word; it.mode = model_mode; it.bad = 1'b1; lat = 0;
    end else begin
      model(r, hs, w, m, lat);
      model_word = w; model_mode = m;
      it.word = w; it.mode = m; it.bad = 1'b0;
    end
    it.at = cyc + 1 + lat;
    it.tag = tag;
    sb.push_back(it);
    pushed++;
    ratio = r; hs_req = hs; rate_zero = z; start = 1'b1;
    @(negedge clk);
    start = 1'b0; rate_zero = 1'b0;
    check({tag, " R9 busy after start"}, 64'(busy), 64'(!z));
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      seen++;
      if (sb.size() == 0) begin
        checks++; failures++;
        $display("FAIL R10 unexpected done actual=1 expected=0");
      end else begin
        item_t e;
        e = sb.pop_front();
        check({e.tag, " timing_word"}, 64'(timing_word), 64'(e.word));
        check({e.tag, " mode_word"}, 64'(mode_word), 64'(e.mode));
        check({e.tag, " R7 bad_rate"}, 64'(bad_rate), 64'(e.bad));
        check({e.tag, " R9 done cycle"}, 64'(cyc), 64'(e.at));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy", 64'(busy), 64'(0));
    check("R1 done", 64'(done), 64'(0));
    check("R1 bad_rate", 64'(bad_rate), 64'(0));
    check("R1 timing_word", 64'(timing_word), 64'h7700_0300);
    check("R1 mode_word", 64'(mode_word), 64'(0));
    rst_n = 1'b1;
    send(32'd0, 1'b0, 1'b0, "R5 ratio0");
    send(32'd1, 1'b0, 1'b0, "R5 ratio1");
    send(32'd15, 1'b0, 1'b0, "R4 ratio15");
    send(32'd16, 1'b0, 1'b0, "R2 ratio16");
    send(32'd17, 1'b0, 1'b0, "R3 ratio17");
    send(32'd31, 1'b0, 1'b0, "R3 ratio31");
    send(32'd48, 1'b0, 1'b0, "R2 ratio48");
    send(32'd1000, 1'b1, 1'b0, "R8 hs");
    send(32'd0, 1'b0, 1'b1, "R7 reject");
    send(32'd524287, 1'b0, 1'b0, "R2 exp15");
    send(32'd524288, 1'b0, 1'b0, "R6 sat");
    send(32'hFFFF_FFFF, 1'b1, 1'b0, "R10 long");
    @(negedge clk);
    ratio = 32'd5; start = 1'b1;
    @(negedge clk);
    rate_zero = 1'b1;
    @(negedge clk);
    start = 1'b0; rate_zero = 1'b0;
    check("R10 still busy", 64'(busy), 64'(1));
    send(32'd100, 1'b0, 1'b0, "R11 b2b_a");
    send(32'd0, 1'b0, 1'b1, "R11 b2b_reject");
    send(32'd200, 1'b1, 1'b0, "R11 b2b_b");
    send(32'd64, 1'b0, 1'b0, "R11 b2b_c");
    while (sb.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    check("R10 completion count", 64'(seen), 64'(pushed));
    check("R9 words held", 64'(timing_word), 64'(model_word));
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule